// File: doc/BRIEF.md
# Byte-Wide Host Register Bridge

This block lets an 8-bit CPU bus reach a bank of 32-bit registers and two receive queues. Register writes are built up one byte at a time in a 32-bit write shadow. The shadow is copied into a register only when an update strobe fires. By default the strobe is the top address bit. A build option instead fires it on every write to the least significant byte. Bytes the CPU skips keep whatever the shadow last held, so a register whose other bytes do not matter can be committed with one byte write.

Reads work the other way round. A load read copies a whole quadlet into a 32-bit read shadow, and the CPU then collects its bytes one at a time. A load read is a read of byte 0 with the update bit set. When the load targets a queue address, the oldest queued quadlet leaves the queue and lands in the shadow. If that queue is empty, the shadow gets zero and a sticky flag records the underflow. The queues are simple models with a push port on the producer side.

The CPU address is nine bits. Bit 8 is the update bit, bits 7..2 select the word, and bits 1..0 select the byte. Byte 0 is bits 31:24 of the quadlet and byte 3 is bits 7:0.

Top module: `hreg_bridge`

## Requirements
- R1: A CPU write puts its data byte into the write shadow byte selected by address bits 1..0. Byte 0 is bits 31:24 and byte 3 is bits 7:0. Each write cycle changes exactly one byte.
- R2: In the default mode, a write with address bit 8 set copies the complete write shadow, including the byte written in that cycle, into the register at word index bits 7..2. The copy takes one clock.
- R3: Shadow bytes that are not written keep their earlier values. A commit therefore stores stale shadow bytes. One byte write to 0x14F commits word 0x13.
- R4: Shadow bytes can be written in any order and repeatedly. The last value written to a byte is the one that is committed.
- R5: In the default mode, a write with bit 8 clear changes no register.
- R6: A read of byte 0 with bit 8 set loads the read shadow from the addressed word. cpu_rdata shows the selected byte of the new shadow after the next clock edge.
- R7: Reads of bytes 1 to 3, and reads of byte 0 with bit 8 clear, do not reload the read shadow and do not pop a queue. They return the byte of the current read shadow.
- R8: Word 62 (0x1F8) and word 63 (0x1FC) are queues 0 and 1. A load read of either one moves its oldest entry into the read shadow and removes it, so entries come out in push order.
- R9: A load read of an empty queue puts zero in the read shadow and sets that queue's bit in q_underflow (bit 0 for queue 0, bit 1 for queue 1). The bit stays set until reset. Nothing is consumed, so a later push is still returned intact.
- R10: After reset the write shadow, the read shadow, cpu_rdata, all registers and q_underflow are zero.
- R11: With AUTO_COMMIT=1, a write to byte 3 commits the shadow whatever bit 8 is. Writes to bytes 0 to 2 commit nothing.
- R12: Commits to word indices from NREG up to 61 are ignored, and load reads of those words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 9 | Byte address: bit 8 update, bits 7..2 word, bits 1..0 byte |
| cpu_wr | input | 1 | Single-cycle write enable |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rd | input | 1 | Single-cycle read enable |
| cpu_rdata | output | 8 | Registered read data byte |
| q0_push | input | 1 | Push one quadlet into queue 0 |
| q0_data | input | 32 | Quadlet pushed into queue 0 |
| q1_push | input | 1 | Push one quadlet into queue 1 |
| q1_data | input | 32 | Quadlet pushed into queue 1 |
| q_underflow | output | 2 | Sticky empty-pop flags, bit n for queue n |

## Verification
Some behaviours are checked by assertions on every cycle:
- a write lands in exactly the selected shadow byte, and the other three bytes are untouched;
- a non-load read leaves the read shadow unchanged;
- the byte returned always matches the read shadow at the selected position;
- the underflow flags never clear outside reset.

Other behaviours can only be shown by the bench's scenarios:
- that a commit reaches the right register with stale bytes included (the 0x14F case);
- that a write with the update bit clear commits nothing;
- that queues give up their entries in push order and an empty pop consumes nothing;
- that out-of-range words stay zero;
- that the byte-3 auto-commit variant behaves as specified.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int BYTE_W = 8;
  localparam int QUAD_W = 32;
  typedef logic [QUAD_W-1:0] quad_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // byte 0 is the most significant byte
  function automatic byte_t quad_byte(quad_t q, logic [1:0] sel);
    return q[(3 - int'(sel)) * BYTE_W +: BYTE_W];
  endfunction

  function automatic quad_t byte_mask(logic [1:0] sel);
    quad_t m;
    m = '0;
    m[(3 - int'(sel)) * BYTE_W +: BYTE_W] = '1;
    return m;
  endfunction

  function automatic quad_t byte_put(quad_t q, logic [1:0] sel, byte_t b);
    quad_t r;
    r = q;
    r[(3 - int'(sel)) * BYTE_W +: BYTE_W] = b;
    return r;
  endfunction
endpackage

// File: rtl/hreg_wshadow.sv
module hreg_wshadow
  import hreg_pkg::*;
#(
  parameter bit AUTO_COMMIT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] byte_sel,
  input  logic       upd,
  input  byte_t      wdata,
  output quad_t      shadow,
  output logic       commit,
  output quad_t      commit_data
);
  quad_t shadow_q, shadow_d;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) shadow_d = byte_put(shadow_q, byte_sel, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shadow_q <= '0;
    else if (wr_en) shadow_q <= shadow_d;
  end

  generate
    if (AUTO_COMMIT) begin : g_auto
      assign commit = wr_en && (byte_sel == 2'd3);
    end else begin : g_strobe
      assign commit = wr_en && upd;
    end
  endgenerate

  assign commit_data = shadow_d;
  assign shadow      = shadow_q;
endmodule

// File: rtl/hreg_bank.sv
module hreg_bank
  import hreg_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  quad_t            wdata,
  input  logic [IDX_W-1:0] ridx,
  output quad_t            rdata
);
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1;

  quad_t regs_q [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic hit;
      assign hit = we && (widx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs_q[g] <= '0;
        else if (hit) regs_q[g] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (int'(ridx) < NREG) rdata = regs_q[ridx[RW-1:0]];
  end
endmodule

// File: rtl/hreg_queue.sv
module hreg_queue
  import hreg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  quad_t push_data,
  input  logic  pop,
  output quad_t head,
  output logic  empty,
  output logic  underflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  quad_t          mem_q [DEPTH];
  logic [PW-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           uf_q, uf_d;
  logic           full, do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wptr_d  = do_push ? ptr_inc(wptr_q) : wptr_q;
    rptr_d  = do_pop  ? ptr_inc(rptr_q) : rptr_q;
    cnt_d   = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    uf_d    = uf_q || (pop && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      uf_q   <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      uf_q   <= uf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= push_data;
  end

  assign head      = mem_q[rptr_q];
  assign underflow = uf_q;
endmodule

// File: rtl/hreg_bridge.sv
module hreg_bridge
  import hreg_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int NREG        = 32,
  parameter int QDEPTH      = 4,
  parameter bit AUTO_COMMIT = 1'b0,
  parameter int Q0_IDX      = 62,
  parameter int Q1_IDX      = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  input  logic              q0_push,
  input  logic [31:0]       q0_data,
  input  logic              q1_push,
  input  logic [31:0]       q1_data,
  output logic [1:0]        q_underflow
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int NQ    = 2;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // address fields
  logic [IDX_W-1:0] idx;
  logic [1:0]       bsel;
  logic             upd;
  assign idx  = cpu_addr[ADDR_W-2:2];
  assign bsel = cpu_addr[1:0];
  assign upd  = cpu_addr[ADDR_W-1];

  // write side
  quad_t wr_shadow, commit_data;
  logic  commit;

  hreg_wshadow #(.AUTO_COMMIT(AUTO_COMMIT)) u_wsh (
    .clk(clk), .rst_n(rst_core_n), .wr_en(cpu_wr), .byte_sel(bsel),
    .upd(upd), .wdata(cpu_wdata), .shadow(wr_shadow),
    .commit(commit), .commit_data(commit_data)
  );

  quad_t bank_rdata;
  hreg_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .we(commit), .widx(idx),
    .wdata(commit_data), .ridx(idx), .rdata(bank_rdata)
  );

  // queues
  logic  rd_load;
  logic  q_push [NQ];
  quad_t q_pdata [NQ];
  quad_t q_head [NQ];
  logic  q_sel [NQ];
  logic  q_pop [NQ];
  logic  q_empty [NQ];
  logic  q_uf [NQ];

  assign q_push[0]  = q0_push;
  assign q_push[1]  = q1_push;
  assign q_pdata[0] = q0_data;
  assign q_pdata[1] = q1_data;
  assign q_sel[0]   = (idx == IDX_W'(Q0_IDX));
  assign q_sel[1]   = (idx == IDX_W'(Q1_IDX));

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_q
      assign q_pop[q] = rd_load && q_sel[q];
      hreg_queue #(.DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_core_n), .push(q_push[q]),
        .push_data(q_pdata[q]), .pop(q_pop[q]), .head(q_head[q]),
        .empty(q_empty[q]), .underflow(q_uf[q])
      );
      assign q_underflow[q] = q_uf[q];
    end
  endgenerate

  // read side
  quad_t rd_src, rd_shadow_q, rd_shadow_d;
  byte_t rdata_q, rdata_d;

  assign rd_load = cpu_rd && (bsel == 2'd0) && upd;

  always_comb begin
    rd_src = bank_rdata;
    for (int q = 0; q < NQ; q++) begin
      if (q_sel[q]) rd_src = q_empty[q] ? '0 : q_head[q];
    end
    rd_shadow_d = rd_load ? rd_src : rd_shadow_q;
    rdata_d     = cpu_rd ? quad_byte(rd_shadow_d, bsel) : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rd_shadow_q <= '0;
      rdata_q     <= '0;
    end else if (cpu_rd) begin
      rd_shadow_q <= rd_shadow_d;
      rdata_q     <= rdata_d;
    end
  end

  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/hreg_bridge_chk.sv
module hreg_bridge_chk
  import hreg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_rd,
  input logic [7:0]        cpu_rdata,
  input logic [1:0]        q_underflow,
  input quad_t             wr_shadow,
  input quad_t             rd_shadow
);
  // R1
  wr_byte_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> quad_byte(wr_shadow, $past(cpu_addr[1:0])) == $past(cpu_wdata));

  // R3
  wr_others_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (wr_shadow & ~byte_mask($past(cpu_addr[1:0])))
               == ($past(wr_shadow) & ~byte_mask($past(cpu_addr[1:0]))));

  // R7
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !(cpu_addr[1:0] == 2'd0 && cpu_addr[ADDR_W-1])) |=> $stable(rd_shadow));

  // R6
  rdata_from_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> cpu_rdata == quad_byte(rd_shadow, $past(cpu_addr[1:0])));

  // R9
  uf0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(q_underflow[0]));

  // R9
  uf1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(q_underflow[1]));
endmodule

bind hreg_bridge hreg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
  .q_underflow(q_underflow), .wr_shadow(wr_shadow), .rd_shadow(rd_shadow_q)
);

// File: tb/hreg_bridge_tb.sv
module hreg_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  cpu_addr;
  logic        cpu_wr, cpu_rd;
  logic [7:0]  cpu_wdata;
  logic [7:0]  rdata_m, rdata_a;
  logic        q0_push, q1_push;
  logic [31:0] q0_data, q1_data;
  logic [1:0]  uf_m, uf_a;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  hreg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(rdata_m),
    .q0_push(q0_push), .q0_data(q0_data), .q1_push(q1_push),
    .q1_data(q1_data), .q_underflow(uf_m)
  );

  hreg_bridge #(.AUTO_COMMIT(1'b1)) u_dut_auto (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(rdata_a),
    .q0_push(q0_push), .q0_data(q0_data), .q1_push(q1_push),
    .q1_data(q1_data), .q_underflow(uf_a)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [7:0] m, output logic [7:0] au);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0; m = rdata_m; au = rdata_a;
  endtask

  task automatic push(int q, logic [31:0] d);
    @(negedge clk);
    if (q == 0) begin q0_push = 1'b1; q0_data = d; end
    else        begin q1_push = 1'b1; q1_data = d; end
    @(negedge clk); q0_push = 1'b0; q1_push = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] m, a;
    check("R10 underflow", {30'd0, uf_m}, 32'd0);
    check("R10 rdata", {24'd0, rdata_m}, 32'd0);
    rd(9'h001, m, a); check("R10 read shadow", {24'd0, m}, 32'd0);
    rd(9'h100, m, a); check("R10 register", {24'd0, m}, 32'd0);
  endtask

  task automatic t_commit();
    logic [7:0] m, a;
    wr(9'h008, 8'h11); wr(9'h009, 8'h22); wr(9'h00A, 8'h33); wr(9'h10B, 8'h44);
    rd(9'h108, m, a); check("R2 R6 byte0", {24'd0, m}, 32'h11);
    rd(9'h009, m, a); check("R1 byte1", {24'd0, m}, 32'h22);
    rd(9'h00A, m, a); check("R1 byte2", {24'd0, m}, 32'h33);
    rd(9'h00B, m, a); check("R1 byte3", {24'd0, m}, 32'h44);
  endtask

  task automatic t_no_commit();
    logic [7:0] m, a;
    wr(9'h00C, 8'hA0); wr(9'h00D, 8'hA1); wr(9'h00E, 8'hA2); wr(9'h00F, 8'hA3);
    rd(9'h10C, m, a); check("R5 byte0", {24'd0, m}, 32'h00);
    rd(9'h00F, m, a); check("R5 byte3", {24'd0, m}, 32'h00);
  endtask

  task automatic t_stale();
    logic [7:0] m, a;
    wr(9'h00D, 8'h77); wr(9'h00D, 8'h99); wr(9'h14F, 8'h5A);
    rd(9'h14C, m, a); check("R3 stale byte0", {24'd0, m}, 32'hA0);
    rd(9'h04D, m, a); check("R4 overwrite", {24'd0, m}, 32'h99);
    rd(9'h04E, m, a); check("R3 stale byte2", {24'd0, m}, 32'hA2);
    rd(9'h04F, m, a); check("R3 written byte3", {24'd0, m}, 32'h5A);
  endtask

  task automatic t_noreload();
    logic [7:0] m, a;
    rd(9'h14C, m, a);
    wr(9'h14F, 8'hC3);
    rd(9'h04F, m, a); check("R7 byte3 not reloaded", {24'd0, m}, 32'h5A);
    rd(9'h04C, m, a); check("R7 byte0 A8 clear", {24'd0, m}, 32'hA0);
    rd(9'h14D, m, a); check("R7 byte1 A8 set", {24'd0, m}, 32'h99);
    rd(9'h04F, m, a); check("R7 still old", {24'd0, m}, 32'h5A);
    rd(9'h14C, m, a);
    rd(9'h04F, m, a); check("R6 reload new", {24'd0, m}, 32'hC3);
  endtask

  task automatic t_queue();
    logic [7:0] m, a;
    push(0, 32'h01020304); push(0, 32'h05060708); push(0, 32'h090A0B0C);
    push(1, 32'hDEADBEEF);
    rd(9'h1F8, m, a); check("R8 q0 first b0", {24'd0, m}, 32'h01);
    rd(9'h0F9, m, a); check("R8 q0 first b1", {24'd0, m}, 32'h02);
    rd(9'h0FA, m, a); check("R8 q0 first b2", {24'd0, m}, 32'h03);
    rd(9'h0FB, m, a); check("R8 q0 first b3", {24'd0, m}, 32'h04);
    rd(9'h1F8, m, a); check("R8 q0 second", {24'd0, m}, 32'h05);
    rd(9'h1FC, m, a); check("R8 q1 b0", {24'd0, m}, 32'hDE);
    rd(9'h0FF, m, a); check("R8 q1 b3", {24'd0, m}, 32'hEF);
    rd(9'h0F8, m, a); check("R7 no pop A8 clear", {24'd0, m}, 32'hDE);
    rd(9'h1F8, m, a); check("R8 q0 third", {24'd0, m}, 32'h09);
    rd(9'h0FB, m, a); check("R8 q0 third b3", {24'd0, m}, 32'h0C);
  endtask

  task automatic t_underflow();
    logic [7:0] m, a;
    rd(9'h1FC, m, a); check("R9 empty b0", {24'd0, m}, 32'h00);
    rd(9'h0FF, m, a); check("R9 empty b3", {24'd0, m}, 32'h00);
    check("R9 flag set", {30'd0, uf_m}, 32'h2);
    push(1, 32'hCAFEF00D);
    rd(9'h1FC, m, a); check("R9 not consumed b0", {24'd0, m}, 32'hCA);
    rd(9'h0FD, m, a); check("R9 not consumed b1", {24'd0, m}, 32'hFE);
    check("R9 flag sticky", {30'd0, uf_m}, 32'h2);
  endtask

  task automatic t_range();
    logic [7:0] m, a;
    wr(9'h180, 8'h12); wr(9'h181, 8'h34); wr(9'h182, 8'h56); wr(9'h183, 8'h78);
    rd(9'h180, m, a); check("R12 out of range b0", {24'd0, m}, 32'h00);
    rd(9'h083, m, a); check("R12 out of range b3", {24'd0, m}, 32'h00);
  endtask

  task automatic t_auto();
    logic [7:0] m, a;
    wr(9'h014, 8'hE1); wr(9'h015, 8'hE2); wr(9'h016, 8'hE3); wr(9'h017, 8'hE4);
    rd(9'h114, m, a);
    check("R11 auto commit b0", {24'd0, a}, 32'hE1);
    check("R5 manual no commit", {24'd0, m}, 32'h00);
    rd(9'h017, m, a); check("R11 auto commit b3", {24'd0, a}, 32'hE4);
    wr(9'h018, 8'hF1);
    rd(9'h118, m, a); check("R11 byte0 no commit", {24'd0, a}, 32'h00);
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = '0;
    q0_push = 1'b0; q1_push = 1'b0; q0_data = '0; q1_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_commit();
    t_no_commit();
    t_stale();
    t_noreload();
    t_queue();
    t_underflow();
    t_range();
    t_auto();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule